// File: doc/BRIEF.md
# Single-Shot Countdown Event Timer

This block raises one interrupt after a programmed number of timebase ticks. Software enables the timer through a control register, then writes a tick count into a value register. That write loads the counter and starts it. The counter steps down once for every clock cycle in which the tick-enable input is high. When it reaches zero it latches a pending flag and stops. The interrupt output is the pending flag gated by an interrupt-enable bit. Software acknowledges the interrupt by writing the clear bit.

The register bus is synchronous: a select, a write strobe, an address and write data, with read data returned combinationally. The timer enable acts as a gate. While it is off, loads of the value register are dropped and the interrupt enable cannot be set. A control write of zero halts the count in place.

Top module: `countdown_event_timer`

## Requirements
- R1: After a synchronous reset, both registers read 0 and `irq` is low.
- R2: The control register is at offset 0x40 and the value register is at 0x44. A control read returns run in bit 0 and interrupt-enable in bit 1, with all other bits 0, including bit 4. A value read returns the remaining count.
- R3: A write to the value register while the run bit (control bit 0) is 0 is ignored, so the count does not change.
- R4: A value write while running loads the count and starts it. The count then drops by exactly one on each clock edge at which `tick_en` is 1, and holds on edges where `tick_en` is 0.
- R5: On the tick that takes the count from 1 to 0, the pending flag is set and counting stops at 0. `irq` is high from that edge while interrupt-enable is 1.
- R6: A control write with bit 0 at 0 clears run and interrupt-enable and freezes the count. Interrupt-enable (bit 1) is taken from a control write only when that same write has bit 0 set.
- R7: A control write with bit 4 set clears the pending flag. A write of 0x11 (clear plus run) therefore leaves `irq` low with interrupt-enable read back as 0.
- R8: If an expiry tick lands on the same edge as a clear write, the expiry wins and the pending flag stays set.
- R9: Loads from 3 up to 0xFFFFFFFF count correctly. A load of 0 starts nothing and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tick_en | input | 1 | Timebase tick qualifier |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the collision between the final tick and an acknowledge write. It needs a clear write on exactly the edge where the count goes from 1 to 0. The bench reaches it by loading 3 and spending two ticks. It then drives the control write and `tick_en` together for a single cycle, and checks that `irq` stays high. Frozen-count and ignored-load cases are checked by reading the value register back after the stimulus.

// File: rtl/countdown_event_timer.sv
module countdown_event_timer #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] CTRL_ADDR = 8'h40,
  parameter logic [AW-1:0] VAL_ADDR  = 8'h44,
  parameter int RUN_BIT = 0,
  parameter int IE_BIT  = 1,
  parameter int CLR_BIT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tick_en,
  output logic          irq
);

  localparam logic [DW-1:0] ONE = DW'(1);

  logic          run, ie, armed, pending;
  logic [DW-1:0] count;

  wire ctrl_wr  = bus_sel & bus_wr & (bus_addr == CTRL_ADDR);
  wire val_req  = bus_sel & bus_wr & (bus_addr == VAL_ADDR);
  wire val_load = val_req & run;
  wire step     = run & armed & tick_en & ~val_load;
  wire expire   = step & (count == ONE);
  wire clr_req  = ctrl_wr & bus_wdata[CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      ie      <= 1'b0;
      armed   <= 1'b0;
      pending <= 1'b0;
      count   <= '0;
    end else begin
      if (ctrl_wr) begin
        run <= bus_wdata[RUN_BIT];
        ie  <= bus_wdata[RUN_BIT] & bus_wdata[IE_BIT];
      end
      if (val_load) begin
        count <= bus_wdata;
        armed <= |bus_wdata;
      end else if (step) begin
        count <= count - ONE;
        if (count == ONE) armed <= 1'b0;
      end
      pending <= expire | (pending & ~clr_req);
    end
  end

  assign irq = pending & ie;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == CTRL_ADDR) begin
        bus_rdata[RUN_BIT] = run;
        bus_rdata[IE_BIT]  = ie;
      end else if (bus_addr == VAL_ADDR) begin
        bus_rdata = count;
      end
    end
  end

  assert_ignored_load_R3: assert property (@(posedge clk) disable iff (rst)
    (val_req && !run) |=> $stable(count));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    (run && armed && tick_en && !val_req) |=> (count == $past(count) - ONE));

  assert_no_tick_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !val_req) |=> $stable(count));

  assert_expire_R5: assert property (@(posedge clk) disable iff (rst)
    (run && armed && tick_en && !val_req && count == ONE) |=> (pending && count == '0));

  assert_stop_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !bus_wdata[RUN_BIT]) |=> (!irq && !run));

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !(run && armed && tick_en && count == ONE)) |=> !pending);

  assert_clear_loses_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_req && run && armed && tick_en && count == ONE) |=> pending);

endmodule

// File: tb/test_countdown_event_timer.sv
`timescale 1ns/1ps
module test_countdown_event_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, tick_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  countdown_event_timer i_countdown_event_timer (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .irq(irq));

  localparam logic [7:0] OW = 8'd1, ORD = 8'd2, OT = 8'd3, OI = 8'd4;
  localparam int NV = 41;
  // {op, req, addr, data, expected}
  localparam logic [87:0] VEC [NV] = '{
    {ORD, 8'd1, 8'h40, 32'd0,   32'd0},  // R1
    {ORD, 8'd1, 8'h44, 32'd0,   32'd0},  // R1
    {OI,  8'd1, 8'h00, 32'd0,   32'd0},  // R1
    {OW,  8'd3, 8'h44, 32'd100, 32'd0},  // R3 load while stopped
    {ORD, 8'd3, 8'h44, 32'd0,   32'd0},
    {OW,  8'd2, 8'h40, 32'h1,   32'd0},
    {ORD, 8'd2, 8'h40, 32'd0,   32'h1},  // R2
    {OW,  8'd4, 8'h44, 32'd10,  32'd0},  // R4
    {ORD, 8'd4, 8'h44, 32'd0,   32'd10},
    {OT,  8'd4, 8'h00, 32'd4,   32'd0},
    {ORD, 8'd4, 8'h44, 32'd0,   32'd6},
    {OW,  8'd2, 8'h40, 32'h3,   32'd0},
    {ORD, 8'd2, 8'h40, 32'd0,   32'h3},  // R2
    {OT,  8'd5, 8'h00, 32'd5,   32'd0},
    {ORD, 8'd5, 8'h44, 32'd0,   32'd1},
    {OI,  8'd5, 8'h00, 32'd0,   32'd0},
    {OT,  8'd5, 8'h00, 32'd1,   32'd0},
    {ORD, 8'd5, 8'h44, 32'd0,   32'd0},  // R5
    {OI,  8'd5, 8'h00, 32'd0,   32'd1},
    {OT,  8'd5, 8'h00, 32'd3,   32'd0},
    {ORD, 8'd5, 8'h44, 32'd0,   32'd0},  // R5 stays at zero
    {OI,  8'd5, 8'h00, 32'd0,   32'd1},
    {OW,  8'd7, 8'h40, 32'h13,  32'd0},  // R7
    {OI,  8'd7, 8'h00, 32'd0,   32'd0},
    {ORD, 8'd7, 8'h40, 32'd0,   32'h3},  // R7 bit 4 reads 0
    {OW,  8'd5, 8'h44, 32'd5,   32'd0},
    {OT,  8'd5, 8'h00, 32'd5,   32'd0},
    {OI,  8'd5, 8'h00, 32'd0,   32'd1},
    {OW,  8'd7, 8'h40, 32'h11,  32'd0},  // R7 clear plus run
    {OI,  8'd7, 8'h00, 32'd0,   32'd0},
    {ORD, 8'd7, 8'h40, 32'd0,   32'h1},
    {OW,  8'd6, 8'h40, 32'h2,   32'd0},  // R6
    {ORD, 8'd6, 8'h40, 32'd0,   32'h0},
    {OW,  8'd6, 8'h40, 32'h1,   32'd0},
    {OW,  8'd6, 8'h44, 32'd20,  32'd0},
    {OT,  8'd6, 8'h00, 32'd3,   32'd0},
    {ORD, 8'd6, 8'h44, 32'd0,   32'd17},
    {OW,  8'd6, 8'h40, 32'h0,   32'd0},  // R6 stop
    {OT,  8'd6, 8'h00, 32'd4,   32'd0},
    {ORD, 8'd6, 8'h44, 32'd0,   32'd17},
    {OI,  8'd6, 8'h00, 32'd0,   32'd0}
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input int req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 check(req, bus_rdata, exp);
    bus_sel = 0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_en = 1;
    end
    @(negedge clk);
    tick_en = 0;
  endtask

  task automatic chk_irq(input int req, input logic exp);
    @(negedge clk);
    check(req, {31'd0, irq}, {31'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    for (int v = 0; v < NV; v++) begin
      case (VEC[v][87:80])
        OW:  wr(VEC[v][71:64], VEC[v][63:32]);
        ORD: rd(int'(VEC[v][79:72]), VEC[v][71:64], VEC[v][31:0]);
        OT:  ticks(int'(VEC[v][63:32]));
        default: chk_irq(int'(VEC[v][79:72]), VEC[v][0]);
      endcase
    end
    // R4: no decrement without tick_en, resumes afterwards
    wr(8'h40, 32'h1);
    repeat (5) @(negedge clk);
    rd(4, 8'h44, 32'd17);
    ticks(2);
    rd(4, 8'h44, 32'd15);
    // R8: clear write on the expiry edge
    wr(8'h40, 32'h3);
    wr(8'h44, 32'd3);
    ticks(2);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h40; bus_wdata = 32'h13; tick_en = 1;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; tick_en = 0;
    check(8, {31'd0, irq}, 32'd1);  // R8
    wr(8'h40, 32'h13);
    chk_irq(7, 1'b0);
    // R9: range ends and zero load
    wr(8'h44, 32'hFFFF_FFFF);
    ticks(1);
    rd(9, 8'h44, 32'hFFFF_FFFE);
    wr(8'h44, 32'd3);
    ticks(3);
    chk_irq(9, 1'b1);
    wr(8'h40, 32'h13);
    wr(8'h44, 32'd0);
    ticks(3);
    chk_irq(9, 1'b0);
    rd(9, 8'h44, 32'd0);
    // R1: reset mid-count
    wr(8'h44, 32'd9);
    ticks(2);
    @(negedge clk) rst = 1;
    @(negedge clk) rst = 0;
    rd(1, 8'h40, 32'd0);
    rd(1, 8'h44, 32'd0);
    chk_irq(1, 1'b0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule